// File: doc/BRIEF.md
# Smartcard Half-Duplex Serial Transceiver

This block moves bytes over a single shared data wire to and from an asynchronous smartcard. A transmitted byte goes out as a frame of one start bit, eight data bits (least significant first) and an even parity bit. The driver then lets go of the wire for a stop period of one and a half bits, so that the far end can pull it low to report a bad parity. A programmable guard time follows before the next frame. Received frames are checked for even parity. When a received frame is bad, the block itself pulls the wire low during that frame's stop period.

The wire is modelled as three signals: a sampled input, a driven value and a driver enable. Only one direction uses the wire at a time. A 16x oversampling tick sets the bit rate, using a divider that the integration sets. A second divider, which can be switched off, produces a clock for the card.

Top module: `sc_uart_top`

## Requirements
- R1: A written byte is sent as 10 bits of 16 ticks each: a start bit of 0, the data bits LSB first, and a parity bit that makes the count of ones over data plus parity even. `line_oe` is 1 for those 10 bits and falls exactly 160 ticks after it rose.
- R2: After the parity bit, `line_oe` stays 0 for a 24-tick stop period and then for a guard of `guard_bits`×16 ticks. `tx_busy` falls at the end of the guard.
- R3: `tx_busy` rises the cycle after an accepted write. The start bit begins no sooner than 8 ticks after the write.
- R4: A frame received with correct parity gives a one-cycle `rd_valid` pulse, with `rd_data` equal to the byte and `rd_perr`=0.
- R5: A frame received with a parity error gives `rd_perr`=1. For 16 ticks from the start of its stop period, the block drives `line_oe`=1 and `line_o`=0.
- R6: The receive stop period is 24 ticks. When `rx_short_stop`=1 and the parity is correct, it is 8 ticks. `rd_valid` is issued at the end of the stop period.
- R7: The receiver checks a falling edge at mid start bit. A low pulse shorter than half a bit produces no `rd_valid`.
- R8: The transmitter samples the wire 12 ticks into its stop period. If the wire is low, `nack_err` is set and stays set until `nack_clr`. If the wire is high, `nack_err` is left unchanged.
- R9: The block ignores the wire on the receive side while `tx_busy`=1, so a transmitted frame produces no `rd_valid`. Transmission starts only while the receiver is idle.
- R10: With `card_clk_en`=1, `card_clk` toggles every `card_clk_div`+1 cycles. With `card_clk_en`=0, it is held low.
- R11: After reset, `line_oe`, `tx_busy`, `rd_valid`, `nack_err` and `card_clk` are 0 and `line_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | DIV_W | Tick period minus one, in clocks (bit = 16 ticks) |
| card_clk_en | input | 1 | Enables the card clock output |
| card_clk_div | input | DIV_W | Card clock half period minus one, in clocks |
| guard_bits | input | GUARD_W | Guard time after the stop period, in bit times |
| rx_short_stop | input | 1 | Shortens the receive stop period to half a bit |
| wr_valid | input | 1 | Loads `wr_data` for transmission when `tx_busy`=0 |
| wr_data | input | 8 | Byte to transmit |
| tx_busy | output | 1 | Transmitter occupied (wait, frame, stop, guard) |
| nack_clr | input | 1 | Clears `nack_err` |
| nack_err | output | 1 | Sticky flag: far end reported a parity error |
| line_i | input | 1 | Sampled level of the shared wire |
| line_o | output | 1 | Value driven onto the wire |
| line_oe | output | 1 | Driver enable for the wire |
| rd_valid | output | 1 | One-cycle pulse: a received byte is ready |
| rd_data | output | 8 | Received byte |
| rd_perr | output | 1 | Received byte had a parity error |
| card_clk | output | 1 | Divided clock for the card |

## Verification
A wrong transmit state or bit counter shows up on `line_o` within one bit time of the fault, because every bit centre of the outgoing frame is sampled. A stop or guard count that is off changes when `line_oe` falls or when `tx_busy` drops, which is measured to within two clocks. Receiver faults show up on the next `rd_valid`, as a wrong byte, a wrong parity flag or a pulse that comes early or late. They also show up in the stop period, where the block drives the wire low only for a bad frame. A stale `nack_err` is visible as soon as the frame ends.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int OSR         = 16;  // ticks per bit
  localparam int HALF        = 8;   // ticks per half bit
  localparam int STOP_TICKS  = 24;  // 1.5 bit stop
  localparam int SHORT_TICKS = 8;   // 0.5 bit stop (receive option)
  localparam int NACK_TICKS  = 16;  // length of the receiver's low pull
  localparam int STOP_PROBE  = 12;  // tick at which tx samples the wire

  typedef enum logic [2:0] {
    TX_IDLE, TX_WAIT, TX_START, TX_DATA, TX_PAR, TX_STOP, TX_GUARD
  } tx_state_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_BITS, RX_TAIL, RX_STOP
  } rx_state_t;
endpackage

// File: rtl/sc_tick_gen.sv
module sc_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             clk_en,
  input  logic [DIV_W-1:0] clk_div,
  output logic             tick,
  output logic             card_clk
);
  logic [DIV_W-1:0] bcnt;
  logic [DIV_W-1:0] ccnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt <= '0;
      tick <= 1'b0;
    end else if (bcnt >= baud_div) begin
      bcnt <= '0;
      tick <= 1'b1;
    end else begin
      bcnt <= bcnt + 1'b1;
      tick <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !clk_en) begin
      ccnt     <= '0;
      card_clk <= 1'b0;
    end else if (ccnt >= clk_div) begin
      ccnt     <= '0;
      card_clk <= ~card_clk;
    end else begin
      ccnt <= ccnt + 1'b1;
    end
  end

  // R10
  card_clk_off_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> !card_clk);
endmodule

// File: rtl/sc_tx.sv
module sc_tx
  import sc_pkg::*;
#(
  parameter int GUARD_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               wr_valid,
  input  logic [7:0]         wr_data,
  input  logic               rx_busy,
  input  logic [GUARD_W-1:0] guard_bits,
  input  logic               line_s,
  input  logic               nack_clr,
  output logic               busy,
  output logic               drv_oe,
  output logic               drv_bit,
  output logic               nack_err
);
  localparam int CNT_W = GUARD_W + 5;

  tx_state_t        state;
  logic [CNT_W-1:0] tcnt;
  logic [2:0]       bidx;
  logic [7:0]       shreg;
  logic             par;
  logic [CNT_W-1:0] guard_last;
  logic             nack_hit;

  assign guard_last = {1'b0, guard_bits, 4'b0000} - 1'b1;
  assign nack_hit   = (state == TX_STOP) && tick &&
                      (tcnt == CNT_W'(STOP_PROBE)) && !line_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE;
      tcnt  <= '0;
      bidx  <= '0;
      shreg <= '0;
      par   <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: if (wr_valid) begin
          shreg <= wr_data;
          par   <= ^wr_data;
          tcnt  <= '0;
          state <= TX_WAIT;
        end
        TX_WAIT: if (tick) begin
          if (tcnt >= CNT_W'(HALF) && !rx_busy) begin
            tcnt  <= '0;
            state <= TX_START;
          end else if (tcnt < CNT_W'(HALF)) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        TX_START: if (tick) begin
          if (tcnt == CNT_W'(OSR - 1)) begin
            tcnt  <= '0;
            bidx  <= '0;
            state <= TX_DATA;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        TX_DATA: if (tick) begin
          if (tcnt == CNT_W'(OSR - 1)) begin
            tcnt  <= '0;
            shreg <= {1'b0, shreg[7:1]};
            if (bidx == 3'd7) state <= TX_PAR;
            else bidx <= bidx + 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        TX_PAR: if (tick) begin
          if (tcnt == CNT_W'(OSR - 1)) begin
            tcnt  <= '0;
            state <= TX_STOP;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        TX_STOP: if (tick) begin
          if (tcnt == CNT_W'(STOP_TICKS - 1)) begin
            tcnt  <= '0;
            state <= (guard_bits == '0) ? TX_IDLE : TX_GUARD;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        TX_GUARD: if (tick) begin
          if (tcnt >= guard_last) begin
            tcnt  <= '0;
            state <= TX_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           nack_err <= 1'b0;
    else if (nack_hit) nack_err <= 1'b1;
    else if (nack_clr) nack_err <= 1'b0;
  end

  always_comb begin
    drv_oe  = 1'b0;
    drv_bit = 1'b1;
    case (state)
      TX_START: begin drv_oe = 1'b1; drv_bit = 1'b0;     end
      TX_DATA:  begin drv_oe = 1'b1; drv_bit = shreg[0]; end
      TX_PAR:   begin drv_oe = 1'b1; drv_bit = par;      end
      default:  ;
    endcase
  end

  assign busy = (state != TX_IDLE);

  // R3
  load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == TX_IDLE && wr_valid) |=> (busy && !drv_oe));
  // R8
  nack_only_in_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nack_err) |-> $past(state) == TX_STOP);
endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line_s,
  input  logic       enable,
  input  logic       short_stop,
  output logic       busy,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       nack_drv
);
  rx_state_t  state;
  logic [4:0] tcnt;
  logic [3:0] bidx;
  logic [8:0] shreg;
  logic       perr_q;
  logic [4:0] stop_last;

  assign stop_last = (short_stop && !perr_q) ? 5'(SHORT_TICKS - 1)
                                             : 5'(STOP_TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      tcnt     <= '0;
      bidx     <= '0;
      shreg    <= '0;
      perr_q   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_perr  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        RX_IDLE: if (tick && enable && !line_s) begin
          tcnt  <= '0;
          state <= RX_START;
        end
        RX_START: if (tick) begin
          if (tcnt == 5'(HALF - 2)) begin
            tcnt  <= '0;
            bidx  <= '0;
            state <= line_s ? RX_IDLE : RX_BITS;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_BITS: if (tick) begin
          if (tcnt == 5'(OSR - 1)) begin
            tcnt  <= '0;
            shreg <= {line_s, shreg[8:1]};
            if (bidx == 4'd8) begin
              perr_q <= ^{line_s, shreg[8:1]};
              state  <= RX_TAIL;
            end else begin
              bidx <= bidx + 1'b1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_TAIL: if (tick) begin
          if (tcnt == 5'(HALF - 1)) begin
            tcnt  <= '0;
            state <= RX_STOP;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (tcnt >= stop_last) begin
            tcnt     <= '0;
            state    <= RX_IDLE;
            rd_valid <= 1'b1;
            rd_data  <= shreg[7:0];
            rd_perr  <= perr_q;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign busy     = (state != RX_IDLE);
  assign nack_drv = (state == RX_STOP) && perr_q && (tcnt < 5'(NACK_TICKS));

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  // R5
  nack_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nack_drv) |-> $past(state) == RX_TAIL);
endmodule

// File: rtl/sc_uart_top.sv
module sc_uart_top #(
  parameter int DIV_W   = 16,
  parameter int GUARD_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIV_W-1:0]   baud_div,
  input  logic               card_clk_en,
  input  logic [DIV_W-1:0]   card_clk_div,
  input  logic [GUARD_W-1:0] guard_bits,
  input  logic               rx_short_stop,
  input  logic               wr_valid,
  input  logic [7:0]         wr_data,
  output logic               tx_busy,
  input  logic               nack_clr,
  output logic               nack_err,
  input  logic               line_i,
  output logic               line_o,
  output logic               line_oe,
  output logic               rd_valid,
  output logic [7:0]         rd_data,
  output logic               rd_perr,
  output logic               card_clk
);
  logic       tick;
  logic [1:0] sync_q;
  logic       line_s;
  logic       tx_oe, tx_bit, rx_busy, rx_drv;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], line_i};
  end
  assign line_s = sync_q[1];

  sc_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .baud_div(baud_div), .clk_en(card_clk_en),
    .clk_div(card_clk_div), .tick(tick), .card_clk(card_clk)
  );

  sc_tx #(.GUARD_W(GUARD_W)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .wr_valid(wr_valid), .wr_data(wr_data),
    .rx_busy(rx_busy), .guard_bits(guard_bits), .line_s(line_s),
    .nack_clr(nack_clr), .busy(tx_busy), .drv_oe(tx_oe), .drv_bit(tx_bit),
    .nack_err(nack_err)
  );

  sc_rx u_rx (
    .clk(clk), .rst(rst), .tick(tick), .line_s(line_s), .enable(!tx_busy),
    .short_stop(rx_short_stop), .busy(rx_busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_perr(rd_perr), .nack_drv(rx_drv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_oe <= 1'b0;
      line_o  <= 1'b1;
    end else begin
      line_oe <= tx_oe | rx_drv;
      line_o  <= rx_drv ? 1'b0 : (tx_oe ? tx_bit : 1'b1);
    end
  end

  // R9
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_oe && rx_drv));
  // R9
  tx_waits_rx_chk: assert property (@(posedge clk) disable iff (rst)
    tx_oe |-> !rx_busy);
endmodule

// File: tb/sc_uart_top_bench.sv
module sc_uart_top_bench;
  localparam int TK = 4;        // clocks per tick (baud_div = 3)
  localparam int TB = 16 * TK;  // clocks per bit

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] baud_div = 16'd3;
  logic card_clk_en = 1'b0;
  logic [15:0] card_clk_div = 16'd2;
  logic [3:0] guard_bits = 4'd0;
  logic rx_short_stop = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic nack_clr = 1'b0;
  logic card_oe = 1'b0;
  logic card_bit = 1'b1;
  logic tx_busy, nack_err, line_o, line_oe, rd_valid, rd_perr, card_clk, line_i;
  logic [7:0] rd_data;

  int errors = 0;
  int checks = 0;
  int rd_count = 0;

  always #5 clk = ~clk;

  assign line_i = line_oe ? line_o : (card_oe ? card_bit : 1'b1);

  always @(posedge clk) if (rd_valid) rd_count <= rd_count + 1;

  sc_uart_top u_sc_uart_top (
    .clk(clk), .rst(rst), .baud_div(baud_div), .card_clk_en(card_clk_en),
    .card_clk_div(card_clk_div), .guard_bits(guard_bits),
    .rx_short_stop(rx_short_stop), .wr_valid(wr_valid), .wr_data(wr_data),
    .tx_busy(tx_busy), .nack_clr(nack_clr), .nack_err(nack_err),
    .line_i(line_i), .line_o(line_o), .line_oe(line_oe), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_perr(rd_perr), .card_clk(card_clk)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R11 line_oe", line_oe == 1'b0, line_oe, 0);
    chk("R11 line_o", line_o == 1'b1, line_o, 1);
    chk("R11 tx_busy", tx_busy == 1'b0, tx_busy, 0);
    chk("R11 rd_valid", rd_valid == 1'b0, rd_valid, 0);
    chk("R11 nack_err", nack_err == 1'b0, nack_err, 0);
    chk("R11 card_clk", card_clk == 1'b0, card_clk, 0);
  endtask

  // Sends one byte and checks framing, timing and the nack flag.
  task automatic t_tx(input logic [7:0] b, input logic [3:0] g, input bit pull);
    int n;
    int rc;
    bit pbit;
    bit nack_before;
    guard_bits = g;
    pbit = ^b;
    rc = rd_count;
    nack_before = nack_err;
    while (tx_busy) @(negedge clk);
    wr_data = b; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R3 busy after write", tx_busy == 1'b1, tx_busy, 1);
    n = 1;
    while (!line_oe && n < 20 * TB) begin @(negedge clk); n++; end
    chk("R3 start delay", n >= 8 * TK && n <= 10 * TK + 2, n, 9 * TK);
    for (int k = 0; k < 10; k++) begin
      bit exp;
      repeat ((k == 0) ? 8 * TK : TB) @(negedge clk);
      exp = (k == 0) ? 1'b0 : (k == 9) ? pbit : b[k-1];
      chk("R1 bit value", line_o == exp && line_oe, {line_oe, line_o}, {1'b1, exp});
    end
    n = 8 * TK + 9 * TB;
    while (line_oe && n < 12 * TB) begin @(negedge clk); n++; end
    chk("R1 oe length", n >= 10 * TB - 1 && n <= 10 * TB + 1, n, 10 * TB);
    if (pull) begin
      repeat (2 * TK) @(negedge clk);
      card_bit = 1'b0; card_oe = 1'b1;
      repeat (18 * TK) @(negedge clk);
      card_oe = 1'b0; card_bit = 1'b1;
      n = 20 * TK;
    end else begin
      n = 0;
    end
    while (tx_busy && n < 20 * TB) begin @(negedge clk); n++; end
    chk("R2 stop+guard", n >= (24 + 16 * g) * TK - 3 && n <= (24 + 16 * g) * TK + 1,
        n, (24 + 16 * g) * TK - 1);
    chk("R8 nack flag", nack_err == (pull | nack_before), nack_err, pull | nack_before);
    chk("R9 no echo", rd_count == rc, rd_count - rc, 0);
  endtask

  task automatic t_nack_clear();
    @(negedge clk); nack_clr = 1'b1;
    @(negedge clk); nack_clr = 1'b0;
    chk("R8 nack cleared", nack_err == 1'b0, nack_err, 0);
  endtask

  // Card sends a frame; checks the block's nack pull, data, and stop length.
  task automatic t_rx(input logic [7:0] b, input bit bad, input bit shorten);
    int rc;
    int n;
    logic [9:0] bits;
    rx_short_stop = shorten;
    rc = rd_count;
    bits = {(^b) ^ bad, b, 1'b0};
    card_oe = 1'b1;
    for (int k = 0; k < 10; k++) begin
      card_bit = bits[k];
      repeat (TB) @(negedge clk);
    end
    card_oe = 1'b0; card_bit = 1'b1;
    n = 0;
    repeat (8 * TK) begin @(negedge clk); n++; end
    if (bad)
      chk("R5 nack pull", line_oe && !line_o, {line_oe, line_o}, 2);
    else
      chk("R4 no pull", !line_oe, line_oe, 0);
    while (rd_count == rc && n < 3 * TB) begin @(negedge clk); n++; end
    chk("R4 rd_valid seen", rd_count == rc + 1, rd_count - rc, 1);
    chk("R4 rd_data", rd_data == b, rd_data, b);
    chk("R5 rd_perr", rd_perr == bad, rd_perr, bad);
    if (shorten && !bad)
      chk("R6 short stop", n < 12 * TK, n, 9 * TK);
    else
      chk("R6 full stop", n >= 20 * TK, n, 25 * TK);
    repeat (2 * TB) @(negedge clk);
  endtask

  task automatic t_glitch();
    int rc;
    rc = rd_count;
    card_bit = 1'b0; card_oe = 1'b1;
    repeat (3 * TK) @(negedge clk);
    card_oe = 1'b0; card_bit = 1'b1;
    repeat (13 * TB) @(negedge clk);
    chk("R7 glitch ignored", rd_count == rc, rd_count - rc, 0);
  endtask

  task automatic t_card_clk();
    int rises;
    logic prev;
    card_clk_div = 16'd2;
    card_clk_en = 1'b1;
    repeat (4) @(negedge clk);
    rises = 0;
    prev = card_clk;
    repeat (120) begin
      @(negedge clk);
      if (card_clk && !prev) rises++;
      prev = card_clk;
    end
    chk("R10 card clock rate", rises >= 19 && rises <= 21, rises, 20);
    card_clk_en = 1'b0;
    repeat (2) @(negedge clk);
    rises = 0;
    repeat (20) begin @(negedge clk); if (card_clk) rises++; end
    chk("R10 card clock off", rises == 0, rises, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx(8'hA5, 4'd0, 1'b0);
    t_tx(8'h01, 4'd2, 1'b0);
    t_tx(8'h7E, 4'd1, 1'b1);
    t_tx(8'hC3, 4'd0, 1'b0);
    t_nack_clear();
    t_rx(8'h3C, 1'b0, 1'b0);
    t_rx(8'h81, 1'b1, 1'b0);
    t_rx(8'hF0, 1'b0, 1'b1);
    t_rx(8'h55, 1'b1, 1'b1);
    t_glitch();
    t_card_clk();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule